// File: doc/BRIEF.md
# Delegated Counter-Inhibit Control Register

This unit owns the 32-bit machine-level counter-inhibit register and drives one inhibit line per hardware counter from it. Machine mode reaches every implemented bit through the machine address. A second address, 0x120, gives supervisor software a window onto the same flops. The window has no storage of its own. A per-counter delegation mask filters it, so supervisor code can see and change only the bits of counters that have been handed to it. A 1 in a bit stops the matching counter from incrementing, and a 0 lets it run.

Each access is presented for one cycle with an address, an operation (read, write, set or clear), write data, the current privilege level and the virtualization flag. The unit checks the access against the counter-delegation enable and the privilege rules. It then commits the new value, or refuses the access with an illegal-instruction or virtual-instruction flag. The response is registered.

A small result machine holds the outcome of the last access. There are four states:
- `ST_IDLE`: no access in the previous cycle.
- `ST_DONE`: the access was accepted.
- `ST_TRAP_ILL`: the access was refused as an illegal instruction.
- `ST_TRAP_VIRT`: the access was refused as a virtual instruction.

There are two transitions:
- Each cycle with `csr_valid_i` high moves the machine from any state to the outcome state the decoder picks.
- Each cycle without an access moves it back to `ST_IDLE`.

Top module: `cinh_csr_unit`

## Requirements
- R1: After reset `inhibit_o`, `rdata_o`, `illegal_o`, `virtual_o` and `done_o` are all zero.
- R2: From machine privilege (priv 2'b11) the machine address 0x320 reaches all implemented bits, whatever the delegation mask. Bits outside `IMPL_MASK` and bit 1 are dropped on write and always read zero.
- R3: The read data of an accepted access at 0x120 is the register value before the access ANDed with `deleg_mask_i`.
- R4: A write through 0x120 changes only bits set in `deleg_mask_i`. Every other bit keeps its value.
- R5: Set (op 2'b10) and clear (op 2'b11) through 0x120 start from the masked view value and merge the result under the delegation mask. Write is op 2'b01 and read is op 2'b00.
- R6: An access to 0x120 while `deleg_en_i` is 0 raises `illegal_o`, leaves the register unchanged and returns zero read data.
- R7: With `deleg_en_i` at 1, an access to 0x120 with `virt_i` high from supervisor (2'b01) or user (2'b00) privilege raises `virtual_o`, changes nothing and returns zero.
- R8: The following accesses raise `illegal_o` and change nothing:
  - a non-virtualized user-mode access to 0x120;
  - any access below machine privilege to 0x320;
  - any access to another address.
- R9: Response outputs and `inhibit_o` update at the clock edge that samples the access. `done_o` is high for exactly the cycle after each access and low otherwise.
- R10: A read operation never alters the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| csr_valid_i | input | 1 | Access strobe, one cycle per access |
| csr_addr_i | input | 12 | CSR address |
| csr_op_i | input | 2 | 00 read, 01 write, 10 set, 11 clear |
| csr_wdata_i | input | 32 | Write / set / clear operand |
| priv_i | input | 2 | 00 user, 01 supervisor, 11 machine |
| virt_i | input | 1 | Virtualization mode active |
| deleg_en_i | input | 1 | Counter-delegation enable from environment config |
| deleg_mask_i | input | 32 | One bit per counter delegated to supervisor |
| rdata_o | output | 32 | Read data (value before the access), zero on trap |
| illegal_o | output | 1 | Illegal-instruction exception for the last access |
| virtual_o | output | 1 | Virtual-instruction exception for the last access |
| done_o | output | 1 | An access was handled in the previous cycle |
| inhibit_o | output | 32 | Per-counter inhibit lines |

## Verification
The bench aims at set and clear through the supervisor window while non-delegated bits hold ones. A design that computed from the unmasked value, or merged outside the mask, would visibly change or expose those bits. It writes ones to bit 1 and to unimplemented bits from both views. A design without the WARL filter would report them in `inhibit_o`. It also sends refused accesses carrying write data from every trapping privilege/virtualization combination. A design that let a trap commit, or that leaked read data on a trap, would change `inhibit_o` or return a nonzero `rdata_o`. A reset in the middle of the run confirms that every output returns to zero.

// File: rtl/cinh_pkg.sv
package cinh_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DONE,
        ST_TRAP_ILL,
        ST_TRAP_VIRT
    } resp_state_e;

    typedef enum logic [1:0] {
        VIEW_NONE,
        VIEW_MACH,
        VIEW_SUP
    } view_e;

    typedef struct packed {
        view_e view;
        logic  trap_ill;
        logic  trap_virt;
    } access_t;
endpackage

// File: rtl/cinh_access_check.sv
module cinh_access_check
    import cinh_pkg::*;
#(
    parameter int          ADDR_W = 12,
    parameter logic [11:0] S_ADDR = 12'h120,
    parameter logic [11:0] M_ADDR = 12'h320
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        priv_i,
    input  logic              virt_i,
    input  logic              deleg_en_i,
    output access_t           acc_o
);
    logic is_m;
    logic is_sview;
    logic is_machine_priv;

    assign is_m            = (addr_i == ADDR_W'(M_ADDR));
    assign is_sview        = (addr_i == ADDR_W'(S_ADDR));
    assign is_machine_priv = (priv_i == PRIV_M);

    always_comb begin
        acc_o = '{view: VIEW_NONE, trap_ill: 1'b0, trap_virt: 1'b0};
        if (is_m) begin
            if (is_machine_priv) acc_o.view = VIEW_MACH;
            else                 acc_o.trap_ill = 1'b1;
        end else if (is_sview) begin
            if (!deleg_en_i)                       acc_o.trap_ill  = 1'b1;
            else if (is_machine_priv)              acc_o.view      = VIEW_SUP;
            else if (virt_i)                       acc_o.trap_virt = 1'b1;
            else if (priv_i == PRIV_S)             acc_o.view      = VIEW_SUP;
            else                                   acc_o.trap_ill  = 1'b1;
        end else begin
            acc_o.trap_ill = 1'b1;
        end
    end
endmodule

// File: rtl/cinh_merge.sv
module cinh_merge
    import cinh_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] cur_i,
    input  logic [CNT_W-1:0] operand_i,
    input  logic [CNT_W-1:0] win_mask_i,
    input  logic [1:0]       op_i,
    output logic [CNT_W-1:0] view_o,
    output logic [CNT_W-1:0] next_o
);
    for (genvar b = 0; b < CNT_W; b++) begin : g_bit
        logic seen;
        logic upd;
        assign seen = cur_i[b] & win_mask_i[b];
        always_comb begin
            unique case (csr_op_e'(op_i))
                OP_READ:  upd = seen;
                OP_WRITE: upd = operand_i[b];
                OP_SET:   upd = seen | operand_i[b];
                OP_CLEAR: upd = seen & ~operand_i[b];
                default:  upd = seen;
            endcase
        end
        assign view_o[b] = seen;
        assign next_o[b] = win_mask_i[b] ? upd : cur_i[b];
    end
endmodule

// File: rtl/cinh_csr_unit.sv
module cinh_csr_unit
    import cinh_pkg::*;
#(
    parameter int          CNT_W     = 32,
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] S_ADDR    = 12'h120,
    parameter logic [11:0] M_ADDR    = 12'h320,
    parameter logic [31:0] IMPL_MASK = 32'h0000_FFFF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              csr_valid_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [1:0]        csr_op_i,
    input  logic [CNT_W-1:0]  csr_wdata_i,
    input  logic [1:0]        priv_i,
    input  logic              virt_i,
    input  logic              deleg_en_i,
    input  logic [CNT_W-1:0]  deleg_mask_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic              illegal_o,
    output logic              virtual_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  inhibit_o
);
    localparam int             TIME_BIT = 1;
    localparam logic [CNT_W-1:0] LEGAL  = CNT_W'(IMPL_MASK) & ~(CNT_W'(1) << TIME_BIT);

    resp_state_e      state_q, state_d;
    access_t          acc;
    logic [CNT_W-1:0] minh_q;
    logic [CNT_W-1:0] rdata_q;
    logic [CNT_W-1:0] win_mask;
    logic [CNT_W-1:0] view_val;
    logic [CNT_W-1:0] next_val;
    logic             commit;

    cinh_access_check #(
        .ADDR_W (ADDR_W),
        .S_ADDR (S_ADDR),
        .M_ADDR (M_ADDR)
    ) u_check (
        .addr_i     (csr_addr_i),
        .priv_i     (priv_i),
        .virt_i     (virt_i),
        .deleg_en_i (deleg_en_i),
        .acc_o      (acc)
    );

    assign win_mask = (acc.view == VIEW_SUP) ? (deleg_mask_i & LEGAL) : LEGAL;

    cinh_merge #(
        .CNT_W (CNT_W)
    ) u_merge (
        .cur_i      (minh_q),
        .operand_i  (csr_wdata_i),
        .win_mask_i (win_mask),
        .op_i       (csr_op_i),
        .view_o     (view_val),
        .next_o     (next_val)
    );

    // next result state
    always_comb begin
        state_d = ST_IDLE;
        if (csr_valid_i) begin
            if (acc.trap_ill)       state_d = ST_TRAP_ILL;
            else if (acc.trap_virt) state_d = ST_TRAP_VIRT;
            else                    state_d = ST_DONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    assign commit = csr_valid_i && (state_d == ST_DONE) && (csr_op_i != OP_READ);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            minh_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (commit) minh_q <= next_val;
            rdata_q <= (state_d == ST_DONE) ? view_val : '0;
        end
    end

    // outputs from the result state
    always_comb begin
        illegal_o = 1'b0;
        virtual_o = 1'b0;
        done_o    = 1'b1;
        unique case (state_q)
            ST_IDLE:      done_o    = 1'b0;
            ST_DONE:      ;
            ST_TRAP_ILL:  illegal_o = 1'b1;
            ST_TRAP_VIRT: virtual_o = 1'b1;
            default:      done_o    = 1'b0;
        endcase
    end

    assign rdata_o   = rdata_q;
    assign inhibit_o = minh_q;
endmodule

// File: rtl/cinh_csr_unit_chk.sv
module cinh_csr_unit_chk #(
    parameter int          CNT_W     = 32,
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] S_ADDR    = 12'h120,
    parameter logic [31:0] IMPL_MASK = 32'h0000_FFFF
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              csr_valid_i,
    input logic [ADDR_W-1:0] csr_addr_i,
    input logic [1:0]        csr_op_i,
    input logic [1:0]        priv_i,
    input logic              virt_i,
    input logic              deleg_en_i,
    input logic [CNT_W-1:0]  deleg_mask_i,
    input logic [CNT_W-1:0]  rdata_o,
    input logic              illegal_o,
    input logic              virtual_o,
    input logic              done_o,
    input logic [CNT_W-1:0]  inhibit_o
);
    localparam logic [CNT_W-1:0] LEGAL = CNT_W'(IMPL_MASK) & ~(CNT_W'(1) << 1);

    logic s_hit;
    logic s_ok;
    assign s_hit = csr_valid_i && (csr_addr_i == ADDR_W'(S_ADDR));
    assign s_ok  = s_hit && deleg_en_i && (priv_i == 2'b01) && !virt_i;

    p_warl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inhibit_o & ~LEGAL) == '0);

    p_sview_rdata_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_ok |=> rdata_o == ($past(inhibit_o) & $past(deleg_mask_i)));

    p_nondeleg_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_ok |=> (inhibit_o & ~$past(deleg_mask_i)) == ($past(inhibit_o) & ~$past(deleg_mask_i)));

    p_cde_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_hit && !deleg_en_i) |=> illegal_o && (rdata_o == '0) && $stable(inhibit_o));

    p_virt_trap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_hit && deleg_en_i && virt_i && priv_i != 2'b11) |=> virtual_o && !illegal_o && $stable(inhibit_o));

    p_trap_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (illegal_o || virtual_o) |-> (rdata_o == '0) && done_o);

    p_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_valid_i |=> done_o);

    p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !csr_valid_i |=> !done_o && !illegal_o && !virtual_o);

    p_read_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_valid_i && csr_op_i == 2'b00) |=> $stable(inhibit_o));
endmodule

bind cinh_csr_unit cinh_csr_unit_chk #(
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W),
    .S_ADDR    (S_ADDR),
    .IMPL_MASK (IMPL_MASK)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .csr_valid_i  (csr_valid_i),
    .csr_addr_i   (csr_addr_i),
    .csr_op_i     (csr_op_i),
    .priv_i       (priv_i),
    .virt_i       (virt_i),
    .deleg_en_i   (deleg_en_i),
    .deleg_mask_i (deleg_mask_i),
    .rdata_o      (rdata_o),
    .illegal_o    (illegal_o),
    .virtual_o    (virtual_o),
    .done_o       (done_o),
    .inhibit_o    (inhibit_o)
);

// File: tb/tb_cinh_csr_unit.sv
module tb_cinh_csr_unit;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        csr_valid_i = 1'b0;
    logic [11:0] csr_addr_i = '0;
    logic [1:0]  csr_op_i = '0;
    logic [31:0] csr_wdata_i = '0;
    logic [1:0]  priv_i = '0;
    logic        virt_i = 1'b0;
    logic        deleg_en_i = 1'b0;
    logic [31:0] deleg_mask_i = '0;
    logic [31:0] rdata_o;
    logic        illegal_o;
    logic        virtual_o;
    logic        done_o;
    logic [31:0] inhibit_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk_i = ~clk_i;

    cinh_csr_unit dut (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .csr_valid_i  (csr_valid_i),
        .csr_addr_i   (csr_addr_i),
        .csr_op_i     (csr_op_i),
        .csr_wdata_i  (csr_wdata_i),
        .priv_i       (priv_i),
        .virt_i       (virt_i),
        .deleg_en_i   (deleg_en_i),
        .deleg_mask_i (deleg_mask_i),
        .rdata_o      (rdata_o),
        .illegal_o    (illegal_o),
        .virtual_o    (virtual_o),
        .done_o       (done_o),
        .inhibit_o    (inhibit_o)
    );

    typedef struct packed {
        logic [11:0] addr;
        logic [1:0]  op;
        logic [31:0] wdata;
        logic [1:0]  priv;
        logic        virt;
        logic        en;
        logic [31:0] mask;
        logic [31:0] erd;
        logic        eill;
        logic        evirt;
        logic [31:0] einh;
        logic [3:0]  req;
    } vec_t;

    // op: 0 read, 1 write, 2 set, 3 clear; priv: 0 U, 1 S, 3 M
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{12'h320, 2'd1, 32'hFFFF_FFFF, 2'd3, 1'b0, 1'b0, 32'h0,         32'h0,      1'b0, 1'b0, 32'h0000_FFFD, 4'd2},  // R2 WARL write
        '{12'h320, 2'd0, 32'h0,         2'd3, 1'b0, 1'b0, 32'h0,         32'hFFFD,   1'b0, 1'b0, 32'h0000_FFFD, 4'd2},  // R2 full read
        '{12'h120, 2'd0, 32'h0,         2'd1, 1'b0, 1'b1, 32'h0000_00F0, 32'h00F0,   1'b0, 1'b0, 32'h0000_FFFD, 4'd3},  // R3 masked read
        '{12'h120, 2'd1, 32'h0,         2'd1, 1'b0, 1'b1, 32'h0000_00F0, 32'h00F0,   1'b0, 1'b0, 32'h0000_FF0D, 4'd4},  // R4 masked write
        '{12'h120, 2'd2, 32'hFFFF_FFFF, 2'd1, 1'b0, 1'b1, 32'h0000_0030, 32'h0,      1'b0, 1'b0, 32'h0000_FF3D, 4'd5},  // R5 set
        '{12'h120, 2'd3, 32'h0000_0010, 2'd1, 1'b0, 1'b1, 32'h0000_0F30, 32'h0F30,   1'b0, 1'b0, 32'h0000_FF2D, 4'd5},  // R5 clear
        '{12'h120, 2'd1, 32'h0,         2'd1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0,      1'b1, 1'b0, 32'h0000_FF2D, 4'd6},  // R6 enable off
        '{12'h120, 2'd1, 32'h0,         2'd1, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0,      1'b0, 1'b1, 32'h0000_FF2D, 4'd7},  // R7 VS
        '{12'h120, 2'd1, 32'h0,         2'd0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0,      1'b1, 1'b0, 32'h0000_FF2D, 4'd8},  // R8 user
        '{12'h320, 2'd1, 32'h0,         2'd1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0,      1'b1, 1'b0, 32'h0000_FF2D, 4'd8},  // R8 S to M addr
        '{12'h123, 2'd0, 32'h0,         2'd3, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0,      1'b1, 1'b0, 32'h0000_FF2D, 4'd8},  // R8 bad addr
        '{12'h120, 2'd0, 32'h0,         2'd3, 1'b0, 1'b1, 32'h0000_000F, 32'h000D,   1'b0, 1'b0, 32'h0000_FF2D, 4'd10}, // R10 M read of window
        '{12'h120, 2'd1, 32'h0000_0002, 2'd1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFF2D,   1'b0, 1'b0, 32'h0000_0000, 4'd4},  // R4 bit1 dropped
        '{12'h120, 2'd1, 32'hFFFF_FFFF, 2'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0,      1'b0, 1'b1, 32'h0000_0000, 4'd7}   // R7 VU
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        // R1 reset state
        chk("R1", inhibit_o, 32'h0);
        chk("R1", {29'd0, done_o, illegal_o, virtual_o}, 32'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R1", rdata_o, 32'h0);

        for (int i = 0; i < NV; i++) begin
            csr_valid_i  = 1'b1;
            csr_addr_i   = VECS[i].addr;
            csr_op_i     = VECS[i].op;
            csr_wdata_i  = VECS[i].wdata;
            priv_i       = VECS[i].priv;
            virt_i       = VECS[i].virt;
            deleg_en_i   = VECS[i].en;
            deleg_mask_i = VECS[i].mask;
            @(negedge clk_i);
            chk($sformatf("R%0d rdata v%0d", VECS[i].req, i), rdata_o, VECS[i].erd);
            chk($sformatf("R%0d flags v%0d", VECS[i].req, i),
                {30'd0, illegal_o, virtual_o}, {30'd0, VECS[i].eill, VECS[i].evirt});
            chk($sformatf("R%0d inhibit v%0d", VECS[i].req, i), inhibit_o, VECS[i].einh);
            chk("R9 done", {31'd0, done_o}, 32'd1);
        end

        // R9: idle cycle drops done and flags
        csr_valid_i = 1'b0;
        @(negedge clk_i);
        chk("R9 idle", {29'd0, done_o, illegal_o, virtual_o}, 32'h0);

        // R2: machine view ignores delegation mask
        csr_valid_i  = 1'b1;
        csr_addr_i   = 12'h320;
        csr_op_i     = 2'd2;
        csr_wdata_i  = 32'hF000_8003;
        priv_i       = 2'd3;
        virt_i       = 1'b0;
        deleg_en_i   = 1'b0;
        deleg_mask_i = 32'h0;
        @(negedge clk_i);
        chk("R2 set", inhibit_o, 32'h0000_8001);
        csr_op_i    = 2'd3;
        csr_wdata_i = 32'h0000_0001;
        @(negedge clk_i);
        chk("R2 clear", inhibit_o, 32'h0000_8000);
        chk("R2 rdata", rdata_o, 32'h0000_8001);

        // R10: read op with write data at window leaves state
        csr_addr_i   = 12'h120;
        csr_op_i     = 2'd0;
        csr_wdata_i  = 32'hFFFF_FFFF;
        priv_i       = 2'd1;
        deleg_en_i   = 1'b1;
        deleg_mask_i = 32'hFFFF_FFFF;
        @(negedge clk_i);
        chk("R10", inhibit_o, 32'h0000_8000);
        csr_valid_i = 1'b0;

        // R1: mid-run reset clears everything
        rst_ni = 1'b0;
        @(negedge clk_i);
        chk("R1 rerun", inhibit_o, 32'h0);
        chk("R1 rerun", {29'd0, done_o, illegal_o, virtual_o}, 32'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        finished = 1'b1;
        finish_run();
    end
endmodule